// File: doc/BRIEF.md
# Four-Product Multiply Add-Subtract-Sum Unit

This block is a pipelined arithmetic unit. It takes eight signed operands in two groups of four, one group per slice. Each slice forms two products. Under its own control bit, the slice adds the second product to the first or subtracts it. A final ALU on the cascade path combines the two slice results with a third, externally supplied addend. Each term has its own sign choice. The ALU can also switch to a bitwise logic mode. An optional round-half-up step is applied to the ALU output. A registered flag pair reports a zero result and a result that has left the signed product range.

Three register stages can each be switched on or off by parameter: after the operand inputs, after the multipliers and at the output. The latency is the number of stages that are on. The per-slice add/subtract bits and the ALU opcode travel through the same enabled stages as the operands. A sample therefore always leaves with the controls it arrived with. A one-bit valid strobe moves through the same stages. Each stage loads only when its valid is set, so the outputs hold between results.

Top module: `mult_add_sum_unit`

## Requirements
- R1: Slice 0 forms P = s0MulA*s0MulB + s0MulC*s0MulD when s0Sub=0, and P = s0MulA*s0MulB - s0MulC*s0MulD when s0Sub=1. All operands are DATA_W-bit signed two's complement.
- R2: Slice 1 forms Q from s1MulA..s1MulD in the same way, with s1Sub choosing subtraction (1) or addition (0), independently of slice 0.
- R3: With logicMode=0, result = P + (negB ? -Q : Q) + (negC ? -E : E), where E is addendIn sign-extended. The result is exact in 2*DATA_W+2 bits for every operand value, so it never wraps.
- R4: With logicMode=1, result is the bitwise function of Q and E (both sign-extended to the result width) selected by logicSel: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 XNOR. negB and negC have no effect in this mode.
- R5: validOut goes high exactly LAT cycles after each validIn sample, where LAT = USE_IN_REG + USE_PIPE_REG + USE_OUT_REG. It is low in every other cycle.
- R6: s0Sub, s1Sub, logicMode, logicSel, negB and negC are sampled together with the operands of the same validIn cycle. Back-to-back samples with different controls each produce their own correct result.
- R7: When validOut is high, eqZeroFlag is 1 exactly when result is zero. rangeFlag is 1 exactly when result lies outside the signed 2*DATA_W-bit range, that is when its top three bits are not all equal.
- R8: With ROUND_EN=1, the ALU value V becomes (V + 2^(ROUND_BIT-1)) with bits below ROUND_BIT cleared, in two's complement. The flags are computed on this rounded value.
- R9: With the output stage enabled, reset clears validOut, result, eqZeroFlag and rangeFlag to 0.
- R10: When at least one stage is enabled, result and both flags keep their value in every cycle in which validOut is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operands and controls on this cycle are a sample |
| s0MulA | input | DATA_W | Slice 0 first product, left operand |
| s0MulB | input | DATA_W | Slice 0 first product, right operand |
| s0MulC | input | DATA_W | Slice 0 second product, left operand |
| s0MulD | input | DATA_W | Slice 0 second product, right operand |
| s0Sub | input | 1 | Slice 0: 1 subtracts the second product, 0 adds it |
| s1MulA | input | DATA_W | Slice 1 first product, left operand |
| s1MulB | input | DATA_W | Slice 1 first product, right operand |
| s1MulC | input | DATA_W | Slice 1 second product, left operand |
| s1MulD | input | DATA_W | Slice 1 second product, right operand |
| s1Sub | input | 1 | Slice 1: 1 subtracts the second product, 0 adds it |
| addendIn | input | DATA_W | Third ALU operand, signed |
| logicMode | input | 1 | 1 selects the bitwise mode, 0 the arithmetic mode |
| logicSel | input | 2 | Bitwise function: 00 AND, 01 OR, 10 XOR, 11 XNOR |
| negB | input | 1 | Negate the slice 1 term in arithmetic mode |
| negC | input | 1 | Negate the addend term in arithmetic mode |
| validOut | output | 1 | result and flags carry a new sample |
| result | output | 2*DATA_W+2 | ALU result, optionally rounded |
| eqZeroFlag | output | 1 | Result equals zero |
| rangeFlag | output | 1 | Result exceeds the signed 2*DATA_W range |

## Verification
The bench drives two configurations from the same stimulus. One has all three stages on and exact output. The other has only the multiplier stage on and rounding at bit 4. Each configuration is checked against its own queued expectations.

The extremes target the wide cases. When all operands are the most negative value, a sum truncated to 36 bits would flip sign and leave rangeFlag wrong. Directed addends of 7, 8, -8, -9 and -24 expose a round that truncates, rounds toward zero or ignores the sign. Back-to-back samples with alternating opcodes and add/sub bits catch controls that slip by one stage relative to their operands. Those would give results mixed from neighbouring samples. Idle gaps confirm that an output stage loading without valid would change result while validOut is low.

// File: rtl/mas_pkg.sv
package mas_pkg;

  typedef enum logic [1:0] {
    LOG_AND  = 2'b00,
    LOG_OR   = 2'b01,
    LOG_XOR  = 2'b10,
    LOG_XNOR = 2'b11
  } logic_op_e;

  // controls that must travel in step with their operands
  typedef struct packed {
    logic      logicMode;
    logic_op_e logicSel;
    logic      negB;
    logic      negC;
    logic      sub0;
    logic      sub1;
  } op_ctrl_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic     ldIn;
    logic     ldPipe;
    logic     ldOut;
    op_ctrl_t aluCtrl;
  } strobe_t;

endpackage

// File: rtl/mas_ctrl.sv
module mas_ctrl
  import mas_pkg::*;
#(
  parameter bit USE_IN_REG   = 1'b1,
  parameter bit USE_PIPE_REG = 1'b1,
  parameter bit USE_OUT_REG  = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     validIn,
  input  op_ctrl_t ctrlIn,
  output strobe_t  strobes,
  output logic     validOut
);

  logic     inValid;
  logic     pipeValid;
  op_ctrl_t inCtrl;
  op_ctrl_t pipeCtrl;

  generate
    if (USE_IN_REG) begin : gInReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          inValid <= 1'b0;
          inCtrl  <= '0;
        end else begin
          inValid <= validIn;
          if (validIn) inCtrl <= ctrlIn;
        end
      end
    end else begin : gInWire
      assign inValid = validIn;
      assign inCtrl  = ctrlIn;
    end

    if (USE_PIPE_REG) begin : gPipeReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pipeValid <= 1'b0;
          pipeCtrl  <= '0;
        end else begin
          pipeValid <= inValid;
          if (inValid) pipeCtrl <= inCtrl;
        end
      end
    end else begin : gPipeWire
      assign pipeValid = inValid;
      assign pipeCtrl  = inCtrl;
    end

    if (USE_OUT_REG) begin : gOutReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validOut <= 1'b0;
        else       validOut <= pipeValid;
      end
    end else begin : gOutWire
      assign validOut = pipeValid;
    end
  endgenerate

  assign strobes = '{ldIn: validIn, ldPipe: inValid, ldOut: pipeValid, aluCtrl: pipeCtrl};

endmodule

// File: rtl/mas_datapath.sv
module mas_datapath
  import mas_pkg::*;
#(
  parameter int DATA_W       = 18,
  parameter bit USE_IN_REG   = 1'b1,
  parameter bit USE_PIPE_REG = 1'b1,
  parameter bit USE_OUT_REG  = 1'b1,
  parameter bit ROUND_EN     = 1'b0,
  parameter int ROUND_BIT    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobes,
  input  logic [1:0][3:0][DATA_W-1:0]   opsIn,
  input  logic [DATA_W-1:0]             addendIn,
  output logic [2*DATA_W+1:0]           result,
  output logic                          eqZeroFlag,
  output logic                          rangeFlag
);

  localparam int PROD_W = 2 * DATA_W;
  localparam int RES_W  = PROD_W + 2;

  logic [1:0][3:0][DATA_W-1:0] opsQ;
  logic [DATA_W-1:0]           addQ1;
  logic [DATA_W-1:0]           addQ2;
  logic [1:0][1:0][PROD_W-1:0] prodD;
  logic [1:0][1:0][PROD_W-1:0] prodQ;
  logic signed [RES_W-1:0]     sliceSum [2];
  logic signed [RES_W-1:0]     opB;
  logic signed [RES_W-1:0]     opC;
  logic signed [RES_W-1:0]     termB;
  logic signed [RES_W-1:0]     termC;
  logic [RES_W-1:0]            aluRes;
  logic [RES_W-1:0]            finalRes;
  logic                        nextZero;
  logic                        nextRange;

  // stage 1: operand registers
  generate
    if (USE_IN_REG) begin : gInReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          opsQ  <= '0;
          addQ1 <= '0;
        end else if (strobes.ldIn) begin
          opsQ  <= opsIn;
          addQ1 <= addendIn;
        end
      end
    end else begin : gInWire
      assign opsQ  = opsIn;
      assign addQ1 = addendIn;
    end
  endgenerate

  // multipliers: product 0 = A*B, product 1 = C*D, per slice
  generate
    for (genvar s = 0; s < 2; s++) begin : gSliceMul
      for (genvar k = 0; k < 2; k++) begin : gMul
        assign prodD[s][k] = PROD_W'($signed(opsQ[s][2*k])) * PROD_W'($signed(opsQ[s][2*k+1]));
      end
    end
  endgenerate

  // stage 2: pipeline registers after the multipliers
  generate
    if (USE_PIPE_REG) begin : gPipeReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prodQ <= '0;
          addQ2 <= '0;
        end else if (strobes.ldPipe) begin
          prodQ <= prodD;
          addQ2 <= addQ1;
        end
      end
    end else begin : gPipeWire
      assign prodQ = prodD;
      assign addQ2 = addQ1;
    end
  endgenerate

  // slice add/subtract
  generate
    for (genvar s = 0; s < 2; s++) begin : gSliceSum
      logic subBit;
      if (s == 0) begin : gSub0
        assign subBit = strobes.aluCtrl.sub0;
      end else begin : gSub1
        assign subBit = strobes.aluCtrl.sub1;
      end
      assign sliceSum[s] = subBit
        ? RES_W'($signed(prodQ[s][0])) - RES_W'($signed(prodQ[s][1]))
        : RES_W'($signed(prodQ[s][0])) + RES_W'($signed(prodQ[s][1]));
    end
  endgenerate

  // cascade ALU: A +/- B +/- C, or bitwise logic on B and C
  assign opB = sliceSum[1];
  assign opC = RES_W'($signed(addQ2));

  always_comb begin
    termB = strobes.aluCtrl.negB ? -opB : opB;
    termC = strobes.aluCtrl.negC ? -opC : opC;
    if (strobes.aluCtrl.logicMode) begin
      unique case (strobes.aluCtrl.logicSel)
        LOG_AND:  aluRes = opB & opC;
        LOG_OR:   aluRes = opB | opC;
        LOG_XOR:  aluRes = opB ^ opC;
        default:  aluRes = ~(opB ^ opC);
      endcase
    end else begin
      aluRes = sliceSum[0] + termB + termC;
    end
  end

  // optional round-half-up at ROUND_BIT
  generate
    if (ROUND_EN) begin : gRound
      localparam logic [RES_W-1:0] HALF_LSB = RES_W'(1) << (ROUND_BIT - 1);
      localparam logic [RES_W-1:0] KEEP_MSK = ~((RES_W'(1) << ROUND_BIT) - RES_W'(1));
      assign finalRes = (aluRes + HALF_LSB) & KEEP_MSK;
    end else begin : gNoRound
      assign finalRes = aluRes;
    end
  endgenerate

  assign nextZero  = (finalRes == '0);
  assign nextRange = !((&finalRes[RES_W-1:PROD_W-1]) || !(|finalRes[RES_W-1:PROD_W-1]));

  // stage 3: output and flag registers
  generate
    if (USE_OUT_REG) begin : gOutReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          result     <= '0;
          eqZeroFlag <= 1'b0;
          rangeFlag  <= 1'b0;
        end else if (strobes.ldOut) begin
          result     <= finalRes;
          eqZeroFlag <= nextZero;
          rangeFlag  <= nextRange;
        end
      end
    end else begin : gOutWire
      assign result     = finalRes;
      assign eqZeroFlag = nextZero;
      assign rangeFlag  = nextRange;
    end
  endgenerate

endmodule

// File: rtl/mult_add_sum_unit.sv
module mult_add_sum_unit
  import mas_pkg::*;
#(
  parameter int DATA_W       = 18,
  parameter bit USE_IN_REG   = 1'b1,
  parameter bit USE_PIPE_REG = 1'b1,
  parameter bit USE_OUT_REG  = 1'b1,
  parameter bit ROUND_EN     = 1'b0,
  parameter int ROUND_BIT    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                validIn,
  input  logic [DATA_W-1:0]   s0MulA,
  input  logic [DATA_W-1:0]   s0MulB,
  input  logic [DATA_W-1:0]   s0MulC,
  input  logic [DATA_W-1:0]   s0MulD,
  input  logic                s0Sub,
  input  logic [DATA_W-1:0]   s1MulA,
  input  logic [DATA_W-1:0]   s1MulB,
  input  logic [DATA_W-1:0]   s1MulC,
  input  logic [DATA_W-1:0]   s1MulD,
  input  logic                s1Sub,
  input  logic [DATA_W-1:0]   addendIn,
  input  logic                logicMode,
  input  logic [1:0]          logicSel,
  input  logic                negB,
  input  logic                negC,
  output logic                validOut,
  output logic [2*DATA_W+1:0] result,
  output logic                eqZeroFlag,
  output logic                rangeFlag
);

  logic [1:0][3:0][DATA_W-1:0] opsPacked;
  op_ctrl_t                    ctrlIn;
  strobe_t                     strobes;

  assign opsPacked[0] = {s0MulD, s0MulC, s0MulB, s0MulA};
  assign opsPacked[1] = {s1MulD, s1MulC, s1MulB, s1MulA};

  assign ctrlIn = '{logicMode: logicMode, logicSel: logic_op_e'(logicSel),
                    negB: negB, negC: negC, sub0: s0Sub, sub1: s1Sub};

  mas_ctrl #(
    .USE_IN_REG  (USE_IN_REG),
    .USE_PIPE_REG(USE_PIPE_REG),
    .USE_OUT_REG (USE_OUT_REG)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .ctrlIn  (ctrlIn),
    .strobes (strobes),
    .validOut(validOut)
  );

  mas_datapath #(
    .DATA_W      (DATA_W),
    .USE_IN_REG  (USE_IN_REG),
    .USE_PIPE_REG(USE_PIPE_REG),
    .USE_OUT_REG (USE_OUT_REG),
    .ROUND_EN    (ROUND_EN),
    .ROUND_BIT   (ROUND_BIT)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .opsIn     (opsPacked),
    .addendIn  (addendIn),
    .result    (result),
    .eqZeroFlag(eqZeroFlag),
    .rangeFlag (rangeFlag)
  );

endmodule

// File: rtl/mas_checker.sv
module mas_checker #(
  parameter int DATA_W       = 18,
  parameter bit USE_IN_REG   = 1'b1,
  parameter bit USE_PIPE_REG = 1'b1,
  parameter bit USE_OUT_REG  = 1'b1,
  parameter bit ROUND_EN     = 1'b0,
  parameter int ROUND_BIT    = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                validIn,
  input logic                validOut,
  input logic [2*DATA_W+1:0] result,
  input logic                eqZeroFlag,
  input logic                rangeFlag
);

  localparam int LAT    = int'(USE_IN_REG) + int'(USE_PIPE_REG) + int'(USE_OUT_REG);
  localparam int PROD_W = 2 * DATA_W;
  localparam int RES_W  = PROD_W + 2;

  logic fitsProd;
  assign fitsProd = (&result[RES_W-1:PROD_W-1]) || !(|result[RES_W-1:PROD_W-1]);

  // R7: flags agree with the result they accompany
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (eqZeroFlag == (result == '0)));

  assert_range_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (rangeFlag == !fitsProd));

  generate
    if (LAT > 0) begin : gLat
      // R5: valid emerges exactly LAT cycles later
      assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
        validOut == $past(validIn, LAT));

      // R10: outputs hold while no new sample is presented
      assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rstN)
        !validOut |-> ($stable(result) && $stable(eqZeroFlag) && $stable(rangeFlag)));
    end else begin : gNoLat
      assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
        validOut == validIn);
    end

    if (ROUND_EN) begin : gRoundChk
      // R8: bits below the rounding position are always clear
      assert_round_low_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
        validOut |-> (result[ROUND_BIT-1:0] == '0));
    end

    if (USE_OUT_REG) begin : gResetChk
      // R9: leaving reset, everything is cleared
      assert_reset_clear_R9: assert property (@(posedge clk)
        $rose(rstN) |-> (!validOut && result == '0 && !eqZeroFlag && !rangeFlag));
    end
  endgenerate

endmodule

bind mult_add_sum_unit mas_checker #(
  .DATA_W      (DATA_W),
  .USE_IN_REG  (USE_IN_REG),
  .USE_PIPE_REG(USE_PIPE_REG),
  .USE_OUT_REG (USE_OUT_REG),
  .ROUND_EN    (ROUND_EN),
  .ROUND_BIT   (ROUND_BIT)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .validOut  (validOut),
  .result    (result),
  .eqZeroFlag(eqZeroFlag),
  .rangeFlag (rangeFlag)
);

// File: tb/sim_mult_add_sum_unit.sv
module sim_mult_add_sum_unit;

  localparam int DW   = 18;
  localparam int RW   = 2 * DW + 2;
  localparam int LAT0 = 3;
  localparam int LAT1 = 1;
  localparam int RBIT = 4;
  localparam logic [RW-1:0] HALF = RW'(1) << (RBIT - 1);

  typedef struct {
    int            due;
    logic [RW-1:0] res;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          validIn = 1'b0;
  logic [DW-1:0] s0MulA = '0, s0MulB = '0, s0MulC = '0, s0MulD = '0;
  logic [DW-1:0] s1MulA = '0, s1MulB = '0, s1MulC = '0, s1MulD = '0;
  logic          s0Sub = 1'b0, s1Sub = 1'b0;
  logic [DW-1:0] addendIn = '0;
  logic          logicMode = 1'b0, negB = 1'b0, negC = 1'b0;
  logic [1:0]    logicSel = 2'b00;

  logic          v0, z0, g0, v1, z1, g1;
  logic [RW-1:0] r0, r1;

  mult_add_sum_unit u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn),
    .s0MulA(s0MulA), .s0MulB(s0MulB), .s0MulC(s0MulC), .s0MulD(s0MulD), .s0Sub(s0Sub),
    .s1MulA(s1MulA), .s1MulB(s1MulB), .s1MulC(s1MulC), .s1MulD(s1MulD), .s1Sub(s1Sub),
    .addendIn(addendIn), .logicMode(logicMode), .logicSel(logicSel), .negB(negB), .negC(negC),
    .validOut(v0), .result(r0), .eqZeroFlag(z0), .rangeFlag(g0)
  );

  mult_add_sum_unit #(
    .USE_IN_REG(1'b0), .USE_PIPE_REG(1'b1), .USE_OUT_REG(1'b0),
    .ROUND_EN(1'b1), .ROUND_BIT(RBIT)
  ) u1 (
    .clk(clk), .rstN(rstN), .validIn(validIn),
    .s0MulA(s0MulA), .s0MulB(s0MulB), .s0MulC(s0MulC), .s0MulD(s0MulD), .s0Sub(s0Sub),
    .s1MulA(s1MulA), .s1MulB(s1MulB), .s1MulC(s1MulC), .s1MulD(s1MulD), .s1Sub(s1Sub),
    .addendIn(addendIn), .logicMode(logicMode), .logicSel(logicSel), .negB(negB), .negC(negC),
    .validOut(v1), .result(r1), .eqZeroFlag(z1), .rangeFlag(g1)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  exp_t          q0[$];
  exp_t          q1[$];
  logic [RW-1:0] last0 = '0;
  logic [RW-1:0] last1 = '0;
  int            errs = 0;
  int            checks = 0;

  // stimulus state
  int op[2][4];
  bit sb0, sb1, lm, nb, nc;
  bit [1:0] ls;
  int ad;

  function automatic int rnd18();
    return int'($urandom_range(0, 262143)) - 131072;
  endfunction

  function automatic void clearStim();
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 4; k++) op[s][k] = 0;
    sb0 = 0; sb1 = 0; lm = 0; nb = 0; nc = 0; ls = 2'b00; ad = 0;
  endfunction

  function automatic logic [RW-1:0] model(bit rnd);
    longint p[2][2];
    longint s[2];
    longint c;
    logic [RW-1:0] r, b, cc;
    for (int i = 0; i < 2; i++) begin
      p[i][0] = longint'(op[i][0]) * longint'(op[i][1]);
      p[i][1] = longint'(op[i][2]) * longint'(op[i][3]);
    end
    s[0] = sb0 ? p[0][0] - p[0][1] : p[0][0] + p[0][1];
    s[1] = sb1 ? p[1][0] - p[1][1] : p[1][0] + p[1][1];
    c = longint'(ad);
    if (lm) begin
      b  = RW'(s[1]);
      cc = RW'(c);
      case (ls)
        2'b00:   r = b & cc;
        2'b01:   r = b | cc;
        2'b10:   r = b ^ cc;
        default: r = ~(b ^ cc);
      endcase
    end else begin
      r = RW'(s[0] + (nb ? -s[1] : s[1]) + (nc ? -c : c));
    end
    if (rnd) r = (r + HALF) & ~((HALF << 1) - RW'(1));
    return r;
  endfunction

  function automatic bit outOfRange(logic [RW-1:0] r);
    return !(r[RW-1:RW-3] == 3'b000 || r[RW-1:RW-3] == 3'b111);
  endfunction

  task automatic tally(bit ok, string req, string who, string what,
                       logic [RW-1:0] act, logic [RW-1:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s %s: actual=%0h expected=%0h (cycle %0d)", req, who, what, act, expv, cyc);
    end
  endtask

  task automatic judge(string who, bit due, exp_t e, logic vo, logic [RW-1:0] r,
                       logic z, logic g, inout logic [RW-1:0] last);
    tally(vo == due, "R5", who, "validOut", RW'(vo), RW'(due));
    if (due) begin
      tally(r == e.res, e.tag, who, "result", r, e.res);
      tally(z == (e.res == '0), "R7", who, "eqZeroFlag", RW'(z), RW'(e.res == '0));
      tally(g == outOfRange(e.res), "R7", who, "rangeFlag", RW'(g), RW'(outOfRange(e.res)));
      last = e.res;
    end else begin
      tally(r == last, "R10", who, "held result", r, last);
    end
  endtask

  task automatic step();
    exp_t blank;
    exp_t e;
    bit   d;
    blank = '{0, '0, ""};
    d = (q0.size() > 0) && (q0[0].due == cyc);
    e = d ? q0[0] : blank;
    if (d) void'(q0.pop_front());
    judge("u0", d, e, v0, r0, z0, g0, last0);
    d = (q1.size() > 0) && (q1[0].due == cyc);
    e = d ? q1[0] : blank;
    if (d) void'(q1.pop_front());
    judge("u1", d, e, v1, r1, z1, g1, last1);
  endtask

  task automatic send(bit v, string tag);
    @(negedge clk);
    step();
    validIn   = v;
    s0MulA    = DW'(op[0][0]); s0MulB = DW'(op[0][1]);
    s0MulC    = DW'(op[0][2]); s0MulD = DW'(op[0][3]);
    s1MulA    = DW'(op[1][0]); s1MulB = DW'(op[1][1]);
    s1MulC    = DW'(op[1][2]); s1MulD = DW'(op[1][3]);
    s0Sub     = sb0; s1Sub = sb1;
    addendIn  = DW'(ad);
    logicMode = lm; logicSel = ls; negB = nb; negC = nc;
    if (v) begin
      q0.push_back('{cyc + LAT0, model(1'b0), tag});
      q1.push_back('{cyc + LAT1, model(1'b1), tag});
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) send(1'b0, "R10");
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    clearStim();
    repeat (3) @(negedge clk);
    // R9: reset state of the fully registered unit
    tally(v0 == 1'b0, "R9", "u0", "validOut in reset", RW'(v0), '0);
    tally(r0 == '0,   "R9", "u0", "result in reset", r0, '0);
    tally(z0 == 1'b0, "R9", "u0", "eqZeroFlag in reset", RW'(z0), '0);
    tally(g0 == 1'b0, "R9", "u0", "rangeFlag in reset", RW'(g0), '0);
    rstN = 1'b1;
    idle(2);

    // R1: slice 0 add then subtract
    clearStim(); op[0] = '{100, 200, 30, 40};
    send(1'b1, "R1");
    sb0 = 1; send(1'b1, "R1");
    op[0] = '{-7, 9, -5, -11}; sb0 = 0; send(1'b1, "R1");
    idle(3);

    // R2: slice 1 alone, both directions
    clearStim(); op[1] = '{-5, 7, 11, 3};
    send(1'b1, "R2");
    sb1 = 1; send(1'b1, "R2");
    idle(4);

    // R3: all sign choices with both slices and addend active
    for (int m = 0; m < 4; m++) begin
      clearStim();
      op[0] = '{1234, -321, 77, 66}; op[1] = '{-900, 450, 13, -2};
      ad = -9; nb = m[0]; nc = m[1];
      send(1'b1, "R3");
    end
    // R3: extreme operands, result beyond product range without wrapping
    clearStim();
    for (int s = 0; s < 2; s++) op[s] = '{-131072, -131072, -131072, -131072};
    ad = -131072; nc = 1;
    send(1'b1, "R3");
    nb = 1; sb1 = 1; send(1'b1, "R3");
    op[1] = '{-131072, 131071, -131072, -131072}; sb1 = 0; nb = 1; nc = 0; ad = 131071;
    send(1'b1, "R3");
    idle(4);

    // R4: each bitwise function, sign controls set and ignored
    for (int f = 0; f < 4; f++) begin
      clearStim();
      op[0] = '{999, 999, 5, 5}; op[1] = '{-300, 77, 1021, 3};
      ad = 12345 - 40000 * f; lm = 1; ls = 2'(f); nb = 1; nc = 1;
      send(1'b1, "R4");
    end
    idle(4);

    // R7: exact cancellation gives a zero result
    clearStim(); op[0] = '{3, 4, 2, 6}; sb0 = 1;
    send(1'b1, "R7");
    idle(4);

    // R8: rounding around the half point, both signs
    foreach (op[s]) op[s] = '{0, 0, 0, 0};
    begin
      int vals[6] = '{8, 7, -8, -9, 24, -24};
      for (int i = 0; i < 6; i++) begin
        clearStim(); ad = vals[i];
        send(1'b1, "R8");
      end
    end
    idle(4);

    // R6: back-to-back samples, controls changing every cycle
    for (int i = 0; i < 16; i++) begin
      clearStim();
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++) op[s][k] = rnd18();
      ad = rnd18();
      sb0 = i[0]; sb1 = i[1]; nb = i[2]; nc = ~i[0]; lm = i[3] ^ i[0]; ls = 2'(i + 1);
      send(1'b1, "R6");
    end
    idle(5);

    // R10 and random coverage with idle gaps
    for (int i = 0; i < 400; i++) begin
      clearStim();
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++) op[s][k] = rnd18();
      ad = rnd18();
      sb0 = 1'($urandom_range(0, 1)); sb1 = 1'($urandom_range(0, 1));
      nb  = 1'($urandom_range(0, 1)); nc  = 1'($urandom_range(0, 1));
      lm  = ($urandom_range(0, 3) == 0); ls = 2'($urandom_range(0, 3));
      send(1'b1, lm ? "R4" : "R3");
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 4)));
    end
    idle(6);
    tally(q0.size() == 0 && q1.size() == 0, "R5", "u0/u1", "outstanding results",
          RW'(q0.size() + q1.size()), '0);
    finishRun();
  end

endmodule